// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block generates eight pulse-width-modulated outputs from one 16-bit up-counter that all channels share. Software programs a counter clock source, a power-of-two prescaler, a period limit and an initial count through a 32-bit register interface at word-aligned byte offsets. Each channel then needs only a compare value and a mode word. The counter runs from the initial count up to the period limit, so one PWM period lasts limit + 1 - initial counts.

Each channel compares the shared count against its own compare value to produce an edge-aligned, high-true waveform. A channel that is not in that mode drives a software-chosen static level instead. The result then passes through a per-channel mask, which forces the inactive level, and a per-channel polarity inversion. The bus writes on one clock edge. Reads are combinational from the address, and the count offset returns the live counter value.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero except the output mask, which reads 0xFF. The counter reads 0, and a read of an unimplemented offset (for example 0x50 or 0x74) returns 0.
- R2: The clock-source field is configuration bits [4:3]. 0 stops the counter. 1 enables it on every clock, 2 on each cycle where `tick_fix` is high, and 3 on each cycle where `tick_ext` is high. An enable from an unselected source has no effect.
- R3: The prescale field is configuration bits [2:0]. The counter advances once per 2^PS source enables. A write to the configuration offset restarts the prescale phase, so with the system source the count after k clocks is k >> PS.
- R4: When the count is at or above the period limit (offset 0x08), the next counter advance loads the initial count (offset 0x4C) instead of adding one.
- R5: A read of offset 0x04 returns the live count. A write to that offset loads the initial count into the counter on the same edge.
- R6: Register offsets are: configuration 0x00, count 0x04, period limit 0x08, initial count 0x4C, static output levels 0x5C, mask 0x60 and polarity 0x70. Channel n has its mode word at 0x0C + 8n and its compare value at 0x10 + 8n. Every implemented field reads back as written; the mode word keeps bits [5:2] only.
- R7: A channel is in edge-aligned PWM mode when mode-word bits [5:4] are 2'b10 and bit 3 is 1. In that mode the channel is high while count < compare and low otherwise. A compare of 0 gives a constant low, and a compare above the period limit gives a constant high.
- R8: A channel not in PWM mode drives bit n of the static output level register.
- R9: Mask bit n set forces channel n to its inactive level (0 before polarity).
- R10: Polarity bit n set inverts the final level of channel n, including a masked one.
- R11: Outputs are combinational from the counter and registers. A counter advance or register write at one edge is visible on `pwm_out` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, registered on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_fix | input | 1 | Enable pulse from the fixed-rate source |
| tick_ext | input | 1 | Enable pulse from the external source |
| pwm_out | output | 8 | Channel outputs after mask and polarity |

## Verification
A write takes effect on the edge that samples it. The counter first advances on the next edge with the system source at prescale 0, and only after 2^PS edges otherwise. Outputs and read data follow the counter with no extra delay. The bench therefore drives every input and samples every result at the falling edge. It keeps its own model of the count from the number of rising edges since the enabling write, and of how many enables of the selected source it has driven. It checks the count read back and all affected channel outputs against that model in the same half-cycle.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

  localparam int OFF_CFG   = 'h00;
  localparam int OFF_CNT   = 'h04;
  localparam int OFF_LIM   = 'h08;
  localparam int OFF_CH0   = 'h0C;
  localparam int CH_STRIDE = 8;
  localparam int OFF_INIT  = 'h4C;
  localparam int OFF_LVL   = 'h5C;
  localparam int OFF_MASK  = 'h60;
  localparam int OFF_POL   = 'h70;
  localparam int PS_W      = 3;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic [CW-1:0]            cnt_val,
  output logic [1:0]               src,
  output logic [PS_W-1:0]          ps,
  output logic [CW-1:0]            lim_val,
  output logic [CW-1:0]            init_val,
  output logic [NCH-1:0][3:0]      ctl,
  output logic [NCH-1:0][CW-1:0]   cmp,
  output logic [NCH-1:0]           lvl,
  output logic [NCH-1:0]           mask,
  output logic [NCH-1:0]           pol,
  output logic                     cfg_wr,
  output logic                     cnt_wr,
  output logic [DW-1:0]            rdata
);
  localparam int IW     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CH_END = OFF_CH0 + CH_STRIDE * NCH;

  logic [AW-1:0] ch_off;
  logic [IW-1:0] ch_idx;
  logic          ch_hit;
  logic          ch_cmp_sel;

  assign ch_off     = addr - AW'(OFF_CH0);
  assign ch_idx     = ch_off[IW+2:3];
  assign ch_cmp_sel = ch_off[2];
  assign ch_hit     = (addr >= AW'(OFF_CH0)) && (addr < AW'(CH_END)) && (addr[1:0] == 2'b00);

  assign cfg_wr = wr_en && (addr == AW'(OFF_CFG));
  assign cnt_wr = wr_en && (addr == AW'(OFF_CNT));

  logic unused_wbits;
  assign unused_wbits = ^wdata[DW-1:CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src      <= '0;
      ps       <= '0;
      lim_val  <= '0;
      init_val <= '0;
      ctl      <= '0;
      cmp      <= '0;
      lvl      <= '0;
      mask     <= '1;
      pol      <= '0;
    end else if (wr_en) begin
      if (cfg_wr) begin
        src <= wdata[4:3];
        ps  <= wdata[2:0];
      end
      if (addr == AW'(OFF_LIM))  lim_val  <= wdata[CW-1:0];
      if (addr == AW'(OFF_INIT)) init_val <= wdata[CW-1:0];
      if (addr == AW'(OFF_LVL))  lvl      <= wdata[NCH-1:0];
      if (addr == AW'(OFF_MASK)) mask     <= wdata[NCH-1:0];
      if (addr == AW'(OFF_POL))  pol      <= wdata[NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (ch_hit && (ch_idx == IW'(i))) begin
          if (ch_cmp_sel) cmp[i] <= wdata[CW-1:0];
          else            ctl[i] <= wdata[5:2];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFF_CFG))       rdata = DW'({src, ps});
    else if (addr == AW'(OFF_CNT))  rdata = DW'(cnt_val);
    else if (addr == AW'(OFF_LIM))  rdata = DW'(lim_val);
    else if (addr == AW'(OFF_INIT)) rdata = DW'(init_val);
    else if (addr == AW'(OFF_LVL))  rdata = DW'(lvl);
    else if (addr == AW'(OFF_MASK)) rdata = DW'(mask);
    else if (addr == AW'(OFF_POL))  rdata = DW'(pol);
    else if (ch_hit) begin
      if (ch_cmp_sel) rdata = DW'(cmp[ch_idx]);
      else            rdata = DW'({ctl[ch_idx], 2'b00});
    end
  end
endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
  import pwm_bank_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      src,
  input  logic [PS_W-1:0] ps,
  input  logic            tick_fix,
  input  logic            tick_ext,
  input  logic            cfg_wr,
  input  logic            cnt_wr,
  input  logic [CW-1:0]   lim_val,
  input  logic [CW-1:0]   init_val,
  output logic            tick,
  output logic [CW-1:0]   cnt
);
  localparam int PCW = (1 << PS_W) - 1;

  logic           src_en;
  logic [PCW-1:0] pre_q, pre_d, pre_lim;
  logic [CW-1:0]  cnt_d;

  always_comb begin
    case (src_e'(src))
      SRC_SYS: src_en = 1'b1;
      SRC_FIX: src_en = tick_fix;
      SRC_EXT: src_en = tick_ext;
      default: src_en = 1'b0;
    endcase
  end

  assign pre_lim = ~({PCW{1'b1}} << ps);
  assign tick    = src_en && (pre_q == pre_lim);

  always_comb begin
    pre_d = pre_q;
    if (cfg_wr)      pre_d = '0;
    else if (tick)   pre_d = '0;
    else if (src_en) pre_d = pre_q + 1'b1;
  end

  always_comb begin
    cnt_d = cnt;
    if (cnt_wr)                cnt_d = init_val;
    else if (tick) begin
      if (cnt >= lim_val)      cnt_d = init_val;
      else                     cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
    end else begin
      pre_q <= pre_d;
      cnt   <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_bank_channel.sv
module pwm_bank_channel #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic [3:0]    ctl,
  input  logic          lvl,
  input  logic          mask,
  input  logic          pol,
  output logic          out
);
  logic edge_mode;
  logic raw;

  assign edge_mode = (ctl[3:2] == 2'b10) && ctl[1];
  assign raw       = edge_mode ? (cnt < cmp) : lvl;
  assign out       = (raw & ~mask) ^ pol;

  logic unused_ctl;
  assign unused_ctl = ctl[0];
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           tick_fix,
  input  logic           tick_ext,
  output logic [NCH-1:0] pwm_out
);
  logic [1:0]             rst_pipe;
  logic                   rst_s_n;
  logic [1:0]             src;
  logic [PS_W-1:0]        ps;
  logic [CW-1:0]          lim_val, init_val, cnt;
  logic [NCH-1:0][3:0]    ctl;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [NCH-1:0]         lvl, mask, pol;
  logic                   cfg_wr, cnt_wr, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  pwm_bank_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cnt_val(cnt), .src(src), .ps(ps), .lim_val(lim_val), .init_val(init_val),
    .ctl(ctl), .cmp(cmp), .lvl(lvl), .mask(mask), .pol(pol),
    .cfg_wr(cfg_wr), .cnt_wr(cnt_wr), .rdata(bus_rdata)
  );

  pwm_bank_timebase #(.CW(CW)) u_time (
    .clk(clk), .rst_n(rst_s_n), .src(src), .ps(ps), .tick_fix(tick_fix),
    .tick_ext(tick_ext), .cfg_wr(cfg_wr), .cnt_wr(cnt_wr), .lim_val(lim_val),
    .init_val(init_val), .tick(tick), .cnt(cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_bank_channel #(.CW(CW)) u_ch (
      .cnt(cnt), .cmp(cmp[g]), .ctl(ctl[g]), .lvl(lvl[g]),
      .mask(mask[g]), .pol(pol[g]), .out(pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     src,
  input logic           tick,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  lim_val,
  input logic [CW-1:0]  init_val,
  input logic           cnt_wr,
  input logic [NCH-1:0] mask,
  input logic [NCH-1:0] pol,
  input logic [NCH-1:0] pwm_out
);
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd0 && !cnt_wr) |=> $stable(cnt)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt < lim_val) |=> cnt == CW'($past(cnt) + 1'b1)); // R3

  AST_WRAP_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt >= lim_val) |=> cnt == $past(init_val)); // R4

  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(init_val)); // R5

  AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out ^ pol) & mask) == '0); // R9
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_s_n), .src(src), .tick(tick), .cnt(cnt),
  .lim_val(lim_val), .init_val(init_val), .cnt_wr(cnt_wr),
  .mask(mask), .pol(pol), .pwm_out(pwm_out)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_fix, tick_ext;
  logic [7:0]  pwm_out;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fix(tick_fix),
    .tick_ext(tick_ext), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic restart(input logic [15:0] init, input logic [15:0] lim);
    wr(8'h00, 0);
    wr(8'h4C, 32'(init));
    wr(8'h08, 32'(lim));
    wr(8'h04, 0);
  endtask

  task automatic t_reset();
    rd_chk("R1 cfg", 8'h00, 0);
    rd_chk("R1 cnt", 8'h04, 0);
    rd_chk("R1 lim", 8'h08, 0);
    rd_chk("R1 cmp7", 8'h48, 0);
    rd_chk("R1 mask", 8'h60, 32'hFF);
    rd_chk("R1 pol", 8'h70, 0);
    rd_chk("R1 hole50", 8'h50, 0);
    rd_chk("R1 hole74", 8'h74, 0);
    check("R9 reset out", 32'(pwm_out), 0);
  endtask

  task automatic t_readback();
    wr(8'h00, 32'h07);   rd_chk("R6 cfg", 8'h00, 32'h07);
    wr(8'h08, 32'h1234); rd_chk("R6 lim", 8'h08, 32'h1234);
    wr(8'h4C, 32'h0056); rd_chk("R6 init", 8'h4C, 32'h0056);
    wr(8'h24, 32'hFF);   rd_chk("R6 ctl3", 8'h24, 32'h3C);
    wr(8'h48, 32'hBEEF); rd_chk("R6 cmp7", 8'h48, 32'hBEEF);
    rd_chk("R6 cmp6 untouched", 8'h40, 0);
    wr(8'h5C, 32'hA5);   rd_chk("R6 lvl", 8'h5C, 32'hA5);
    wr(8'h70, 32'h81);   rd_chk("R6 pol", 8'h70, 32'h81);
    wr(8'h24, 0); wr(8'h48, 0); wr(8'h5C, 0); wr(8'h70, 0);
    rd_chk("R1 hole50 after writes", 8'h50, 0);
  endtask

  task automatic t_period();
    restart(16'd0, 16'd4);
    rd_chk("R5 load", 8'h04, 0);
    wr(8'h00, 32'h08);
    for (int k = 0; k < 12; k++) begin
      rd_chk("R4 wrap count", 8'h04, 32'(k % 5));
      step();
    end
  endtask

  task automatic t_init();
    restart(16'd2, 16'd5);
    rd_chk("R5 load init", 8'h04, 2);
    wr(8'h00, 32'h08);
    for (int k = 0; k < 10; k++) begin
      rd_chk("R4 init wrap", 8'h04, 32'(2 + (k % 4)));
      step();
    end
  endtask

  task automatic t_prescale(input int p);
    restart(16'd0, 16'hFFFF);
    wr(8'h00, 32'(8 | p));
    for (int k = 0; k < 20; k++) begin
      rd_chk("R3 prescale", 8'h04, 32'(k >> p));
      step();
    end
  endtask

  task automatic t_source();
    int exp_c = 0;
    restart(16'd0, 16'hFFFF);
    wr(8'h00, 32'h10);
    for (int k = 0; k < 12; k++) begin
      rd_chk("R2 fixed source", 8'h04, 32'(exp_c));
      tick_fix = (k % 3 == 0); tick_ext = 1'b1;
      step();
      if (k % 3 == 0) exp_c++;
    end
    wr(8'h00, 32'h18);
    for (int k = 0; k < 12; k++) begin
      rd_chk("R2 external source", 8'h04, 32'(exp_c));
      tick_ext = (k % 2 == 0); tick_fix = 1'b1;
      step();
      if (k % 2 == 0) exp_c++;
    end
    wr(8'h00, 32'h00);
    tick_fix = 1'b1; tick_ext = 1'b1;
    for (int k = 0; k < 5; k++) step();
    rd_chk("R2 source off", 8'h04, 32'(exp_c));
    tick_fix = 1'b0; tick_ext = 1'b0;
  endtask

  task automatic t_pwm();
    restart(16'd0, 16'd9);
    wr(8'h0C, 32'h28); wr(8'h10, 3);
    wr(8'h14, 32'h28); wr(8'h18, 0);
    wr(8'h1C, 32'h28); wr(8'h20, 10);
    wr(8'h24, 32'h28); wr(8'h28, 7);
    wr(8'h70, 32'h08);
    wr(8'h60, 32'hF0);
    wr(8'h00, 32'h08);
    for (int k = 0; k < 20; k++) begin
      int c = k % 10;
      logic [3:0] e;
      e = {~(c < 7), 1'b1, 1'b0, (c < 3)};
      check("R7 R10 R11 edge pwm", 32'(pwm_out[3:0]), 32'(e));
      step();
    end
  endtask

  task automatic t_mask_mode();
    wr(8'h34, 32'h24);
    wr(8'h3C, 32'h28); wr(8'h40, 10);
    wr(8'h5C, 32'h10);
    wr(8'h70, 32'h88);
    wr(8'h60, 32'hC0);
    check("R8 R9 R10 mixed", 32'(pwm_out[7:4]), 32'b1001);
    wr(8'h60, 32'h80);
    check("R7 unmask above limit", 32'(pwm_out[6]), 1);
    wr(8'h60, 32'hFF);
    check("R9 all masked", 32'(pwm_out), 32'h88);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    tick_fix = 1'b0; tick_ext = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readback();
    t_period();
    t_init();
    t_prescale(1);
    t_prescale(3);
    t_source();
    t_pwm();
    t_mask_mode();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule